// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller sits on the host side of a parallel, asynchronous NOR-style flash bus and erases one block on request. After a one-cycle `start` pulse with an address inside the target block, it writes the two-step erase command pair to that address. It then reads the device status byte over and over, with one output-enable pulse per read, until the ready bit reports completion. Every strobe is timed by a cycle counter. Setup, strobe width and hold are parameters, so one build can meet the timing of a slower or faster part at a given system clock.

When the erase finishes, the sequencer decodes the error bits of the status byte into a result code. If any error bit is set, it writes the clear-status command so that the sticky bits are gone before the host sees the result. A poll limit stops the operation with a timeout code if the device never reports ready. Every operation ends with a read-array command, which leaves the flash readable, and then a single `done` pulse.

Top module: `blk_erase_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe`, `busy` and `done` are 0.
- R2: A `start` pulse in idle makes the sequencer write 20h and then D0h, both to `blk_addr`, before any status read.
- R3: In every write cycle, `fl_we_n` is low for exactly PULSE_CYC clock cycles. During that time `fl_ce_n` is low, `fl_dq_oe` is 1, and `fl_addr` and `fl_dq_out` do not change. `fl_we_n` and `fl_oe_n` are never low together, and neither is low while `fl_ce_n` is high.
- R4: Each status read is its own `fl_oe_n` low pulse at `blk_addr`. Reads repeat while status bit 7 (ready) reads 0.
- R5: If status bit 7 is 1 and bits 5, 4, 3 and 1 are all 0, the result is 0 (pass). No clear command is written, and bits 6, 2 and 0 are ignored.
- R6: If bit 7 is 1 and bit 5 is 1, the result is 1 when bit 3 is set (program-voltage fault), otherwise 2 when bit 1 is set (locked block), otherwise 3 when bit 4 is set (bad command sequence), otherwise 5. Any other combination of bits 4, 3 or 1 without bit 5 gives 5.
- R7: If bit 7 is 1 and any of bits 5, 4, 3 or 1 is set, the sequencer writes 50h to `blk_addr` after the last status read and before the read-array write.
- R8: If MAX_POLLS reads in a row return bit 7 = 0, polling stops after exactly MAX_POLLS reads, the result is 4 (timeout) and no 50h is written. A device that becomes ready on read number MAX_POLLS still passes.
- R9: Every operation ends with a write of FFh to `blk_addr`. Then `done` is high for exactly one cycle. `busy` falls in that same cycle, and `result` holds its value until the next operation ends.
- R10: A `start` pulse while `busy` is high is ignored: no command goes to its address and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle erase request, taken only when idle |
| blk_addr | input | AW | Address inside the block to erase |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 pass, 1 voltage, 2 locked, 3 sequence, 4 timeout, 5 other failure |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven onto the flash data bus |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | DW | Data read from the flash data bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the sequencer with a 12-bit address, two setup cycles, a three-cycle strobe, one hold cycle and MAX_POLLS = 5. The three-cycle strobe makes a pulse-width error visible as a run-length mismatch. The small poll limit makes both boundaries reachable in a few hundred cycles: a device that becomes ready on the fifth read passes, and one that never becomes ready times out after exactly five reads. A bus model in the bench returns the chosen status bytes, logs every write cycle and measures every strobe.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    RES_PASS    = 3'd0,
    RES_VOLT    = 3'd1,
    RES_LOCK    = 3'd2,
    RES_SEQ     = 3'd3,
    RES_TIMEOUT = 3'd4,
    RES_FAIL    = 3'd5
  } res_e;

  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;

  localparam int SB_READY = 7;
  localparam int SB_ERASE = 5;
  localparam int SB_SEQ   = 4;
  localparam int SB_VOLT  = 3;
  localparam int SB_LOCK  = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_POLL, S_CHECK, S_CLEAR, S_RDARR, S_FIN
  } seq_st_e;
endpackage

// File: rtl/erase_bus_cycle.sv
module erase_bus_cycle #(
  parameter int AW        = 22,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SET, PH_STB, PH_HLD} ph_e;
  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      ack       <= 1'b0;
      rd_data   <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (ph)
        PH_IDLE: if (req) begin
          fl_addr   <= req_addr;
          fl_dq_out <= req_data;
          fl_dq_oe  <= req_wr;
          wr_q      <= req_wr;
          fl_ce_n   <= 1'b0;
          cnt       <= CW'(SETUP_CYC - 1);
          ph        <= PH_SET;
        end
        PH_SET: if (cnt == '0) begin
          if (wr_q) fl_we_n <= 1'b0;
          else      fl_oe_n <= 1'b0;
          cnt <= CW'(PULSE_CYC - 1);
          ph  <= PH_STB;
        end else cnt <= cnt - 1'b1;
        PH_STB: if (cnt == '0) begin
          fl_we_n <= 1'b1;
          fl_oe_n <= 1'b1;
          if (!wr_q) rd_data <= fl_dq_in;
          cnt <= CW'(HOLD_CYC - 1);
          ph  <= PH_HLD;
        end else cnt <= cnt - 1'b1;
        PH_HLD: if (cnt == '0) begin
          fl_ce_n  <= 1'b1;
          fl_dq_oe <= 1'b0;
          ack      <= 1'b1;
          ph       <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_fault_decode.sv
module erase_fault_decode
  import erase_seq_pkg::*;
(
  input  logic [7:0] sr,
  output logic       ready,
  output logic       any_err,
  output res_e       code
);
  always_comb begin
    ready   = sr[SB_READY];
    any_err = sr[SB_ERASE] | sr[SB_SEQ] | sr[SB_VOLT] | sr[SB_LOCK];
    if (!any_err)            code = RES_PASS;
    else if (!sr[SB_ERASE])  code = RES_FAIL;
    else if (sr[SB_VOLT])    code = RES_VOLT;
    else if (sr[SB_LOCK])    code = RES_LOCK;
    else if (sr[SB_SEQ])     code = RES_SEQ;
    else                     code = RES_FAIL;
  end
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int AW        = 22,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 1,
  parameter int MAX_POLLS = 100000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] blk_addr,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  seq_st_e       st, next_st;
  logic          req, pend, ack;
  logic          req_wr;
  logic [DW-1:0] req_data;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] addr_q;
  logic [7:0]    sr_q;
  logic [PW-1:0] polls;
  res_e          code_q, dec_code;
  logic          dec_ready, dec_err;

  erase_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(addr_q),
    .req_data(req_data), .ack(ack), .rd_data(rd_data),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  erase_fault_decode u_dec (
    .sr(sr_q), .ready(dec_ready), .any_err(dec_err), .code(dec_code)
  );

  always_comb begin
    req_wr   = (st != S_POLL);
    req_data = DW'(CMD_READ_ARRAY);
    next_st  = S_IDLE;
    case (st)
      S_SETUP:   begin req_data = DW'(CMD_ERASE_SETUP);   next_st = S_CONFIRM; end
      S_CONFIRM: begin req_data = DW'(CMD_ERASE_CONFIRM); next_st = S_POLL;    end
      S_POLL:    begin req_data = '0;                     next_st = S_CHECK;   end
      S_CLEAR:   begin req_data = DW'(CMD_CLEAR_STATUS);  next_st = S_RDARR;   end
      S_RDARR:   begin req_data = DW'(CMD_READ_ARRAY);    next_st = S_FIN;     end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      req    <= 1'b0;
      pend   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= RES_PASS;
      addr_q <= '0;
      sr_q   <= '0;
      polls  <= '0;
      code_q <= RES_PASS;
    end else begin
      req  <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= blk_addr;
          busy   <= 1'b1;
          polls  <= '0;
          st     <= S_SETUP;
        end
        S_SETUP, S_CONFIRM, S_POLL, S_CLEAR, S_RDARR: begin
          if (!pend) begin
            req  <= 1'b1;
            pend <= 1'b1;
          end else if (ack) begin
            pend <= 1'b0;
            st   <= next_st;
            if (st == S_POLL) begin
              sr_q  <= rd_data[7:0];
              polls <= polls + 1'b1;
            end
          end
        end
        S_CHECK: begin
          if (dec_ready) begin
            code_q <= dec_code;
            st     <= dec_err ? S_CLEAR : S_RDARR;
          end else if (polls == PW'(MAX_POLLS)) begin
            code_q <= RES_TIMEOUT;
            st     <= S_RDARR;
          end else begin
            st <= S_POLL;
          end
        end
        S_FIN: begin
          done   <= 1'b1;
          busy   <= 1'b0;
          result <= code_q;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_erase_seq_chk.sv
module blk_erase_seq_chk #(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [2:0]    result,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));  // R3
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);  // R3
  AST_WRITE_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));  // R3
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);  // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);  // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));  // R9
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    result <= 3'd5);  // R6
endmodule

bind blk_erase_seq blk_erase_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .result(result),
  .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/blk_erase_seq_bench.sv
module blk_erase_seq_bench;
  localparam int AW = 12, DW = 8, SETUP = 2, PULSE = 3, HOLD = 1, MAXP = 5;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] blk_addr = '0;
  logic          busy, done, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
  logic [2:0]    result;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;
  logic [DW-1:0] fl_dq_in = '0;

  always #4 clk = ~clk;

  blk_erase_seq #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
                  .HOLD_CYC(HOLD), .MAX_POLLS(MAXP)) u_blk_erase_seq (
    .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr), .busy(busy),
    .done(done), .result(result), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  int n_chk = 0, n_bad = 0;
  // bus model state
  int          busy_reads = 0;
  logic [7:0]  final_sr = 8'h80;
  int          rcnt = 0, wcnt = 0, done_cnt = 0, bad_bus = 0, we_run = 0;
  logic [AW-1:0] wl_addr [8];
  logic [7:0]    wl_data [8];
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_dq;
  logic          prev_we = 1'b1, prev_oe = 1'b1;
  logic [2:0]    res_done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_we_n && prev_we) begin
        cap_addr = fl_addr; cap_dq = fl_dq_out; we_run = 1;
        if (fl_ce_n || !fl_dq_oe) bad_bus++;
      end else if (!fl_we_n) begin
        we_run++;
        if (fl_addr != cap_addr || fl_dq_out != cap_dq || fl_ce_n || !fl_dq_oe) bad_bus++;
      end else if (!prev_we) begin
        if (we_run != PULSE) bad_bus++;
        if (wcnt < 8) begin wl_addr[wcnt] = cap_addr; wl_data[wcnt] = cap_dq; end
        wcnt++;
      end
      if (!fl_oe_n && prev_oe) begin
        if (fl_ce_n) bad_bus++;
        fl_dq_in = (rcnt < busy_reads) ? 8'h00 : final_sr;
        rcnt++;
      end
      if (done) begin done_cnt++; res_done = result; end
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  task automatic launch(input logic [AW-1:0] a, input int br, input logic [7:0] sr);
    busy_reads = br; final_sr = sr; rcnt = 0; wcnt = 0; done_cnt = 0; bad_bus = 0;
    @(negedge clk); start = 1'b1; blk_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_log(input string req, input logic [AW-1:0] a, input bit with_clear);
    logic [7:0] exp_d [4];
    int n;
    exp_d[0] = 8'h20; exp_d[1] = 8'hD0;
    if (with_clear) begin exp_d[2] = 8'h50; exp_d[3] = 8'hFF; n = 4; end
    else begin exp_d[2] = 8'hFF; exp_d[3] = 8'h00; n = 3; end
    chk(wcnt == n, {req, " write count"}, wcnt, n);
    for (int i = 0; i < n && i < wcnt; i++) begin
      chk(wl_data[i] == exp_d[i], {req, " command byte"}, int'(wl_data[i]), int'(exp_d[i]));
      chk(wl_addr[i] == a, {req, " command address"}, int'(wl_addr[i]), int'(a));
    end
    chk(bad_bus == 0, "R3 strobe shape / bus stability", bad_bus, 0);
  endtask

  task automatic check_end(input string req, input int exp_res);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    chk(res_done == 3'(exp_res), {req, " result at done"}, int'(res_done), exp_res);
    chk(!busy, "R9 busy low after done", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(result == 3'(exp_res), "R9 result held", int'(result), exp_res);
  endtask

  task automatic t_reset();
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes idle", int'({fl_ce_n, fl_oe_n, fl_we_n}), 7);
    chk(!fl_dq_oe && !busy && !done, "R1 flags clear", int'({fl_dq_oe, busy, done}), 0);
  endtask

  task automatic t_pass(input logic [AW-1:0] a, input int br, input logic [7:0] sr);
    launch(a, br, sr); wait_done();
    check_log("R2 R5 pass", a, 1'b0);
    chk(rcnt == br + 1, "R4 one read per poll", rcnt, br + 1);
    check_end("R5", 0);
  endtask

  task automatic t_fault(input logic [7:0] sr, input int exp_res);
    launch(12'h3A0, 1, sr); wait_done();
    check_log("R7 clear before read-array", 12'h3A0, 1'b1);
    chk(rcnt == 2, "R4 reads", rcnt, 2);
    check_end("R6", exp_res);
  endtask

  task automatic t_timeout();
    launch(12'h055, 1000, 8'h80); wait_done();
    check_log("R8 timeout commands", 12'h055, 1'b0);
    chk(rcnt == MAXP, "R8 reads before timeout", rcnt, MAXP);
    check_end("R8", 4);
  endtask

  task automatic t_start_busy();
    launch(12'h111, 3, 8'h80);
    repeat (15) @(negedge clk);
    start = 1'b1; blk_addr = 12'h222;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    check_log("R10 ignored start", 12'h111, 1'b0);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(!busy, "R10 no second operation", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pass(12'h100, 0, 8'h80);
    t_pass(12'hABC, 3, 8'h80);
    t_pass(12'h7F0, MAXP - 1, 8'h80);   // R8 ready on last allowed read
    t_pass(12'h001, 2, 8'hC5);          // R5 bits 6, 2, 0 ignored
    t_fault(8'hA8, 1);                  // R6 voltage
    t_fault(8'hA2, 2);                  // R6 locked
    t_fault(8'hB0, 3);                  // R6 sequence
    t_fault(8'hBA, 1);                  // R6 voltage wins
    t_fault(8'hB2, 2);                  // R6 lock over sequence
    t_fault(8'hA0, 5);                  // R6 erase fail only
    t_fault(8'h90, 5);                  // R6 no bit 5
    t_timeout();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule